// File: doc/BRIEF.md
# Effective Clock and Load Monitor

This block measures how a core spends its cycles over a measurement window whose length is programmed in reference-clock ticks. In every core cycle it counts the cycle itself, whether the core did useful work, and, separately, the same two counts restricted to cycles flagged as belonging to a forced full-load sample. A cycle is busy only when at least one hardware thread is busy and the clock modulator is not forcing the core idle. Idle threads, halted cycles and modulator-stolen cycles all count as lost capacity. A fully busy but throttled core therefore reads below 100% load.

When a window closes, the four counts are captured and the counters restart on the same edge. A single shared shift-subtract divider then produces three results one after the other: the load fraction, the busy ratio seen during the full-load sample, and the actual clock rate in core cycles per reference tick. The effective clock is the sample ratio multiplied by the actual rate. All three results are published together with a one-cycle valid pulse. Software programs the window length, for example a short window for quick response or a long one for accuracy. Writing zero stops measurement.

Top module: `eff_clock_monitor`

## Requirements
- R1: While `rst` is high, and after it is released until the first result, `result_valid` is low and `load_frac`, `rate` and `eff_rate` are zero.
- R2: A window starts on the first cycle after reset, after a close, or after `win_len` becomes nonzero. It closes on the cycle whose `ref_tick` makes the tick count since the window began reach at least `win_len`. That closing cycle belongs to the closing window, and the next window starts on the following cycle, so no cycle is dropped or counted twice.
- R3: `rate` equals floor(T * 2^RATE_FRAC / W). T is the number of cycles in the window, W is the `win_len` value present in the closing cycle, and the low RATE_FRAC bits are the fraction of cycles per reference tick.
- R4: `load_frac` equals floor(B * 65536 / T), where B is the number of busy cycles in the window. A value of 65536 or more is reported as 0xFFFF.
- R5: A cycle is busy only when at least one bit of `thread_busy` is high and `forced_idle` is low. Cycles that are forced idle, or in which no thread is busy, are non-busy.
- R6: Let SB be the busy cycles and ST all cycles with `full_load_sample` high in the window. The ratio Q is floor(SB * 65536 / ST), saturated to 0xFFFF, and Q is 0xFFFF when ST is zero. `eff_rate` equals floor(Q * rate / 65536), so it never exceeds `rate`.
- R7: `result_valid` is high for exactly one cycle, 3*(CNT_W+16)+1 cycles after the closing cycle of an accepted window. The three result outputs change only on that pulse.
- R8: A window that closes 3*(CNT_W+16) cycles or fewer after the closing cycle of the previously accepted window produces no result. The counters still restart.
- R9: While `win_len` is zero, no window closes, all counters stay cleared and the outputs hold their last values. A result already in progress still completes.
- R10: Busy is judged for the whole core. Several threads busy in the same cycle add one busy cycle, not one per thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock tick |
| thread_busy | input | THREADS | Per-thread busy (not halted) indication |
| forced_idle | input | 1 | Cycle is removed by the clock modulator |
| full_load_sample | input | 1 | Cycle belongs to a forced full-load sample |
| win_len | input | WIN_W | Window length in reference ticks; zero disables |
| result_valid | output | 1 | One-cycle pulse with each new result |
| load_frac | output | 16 | Load fraction, 0xFFFF near 100% |
| rate | output | CNT_W+RATE_FRAC | Core cycles per reference tick, fixed point |
| eff_rate | output | CNT_W+RATE_FRAC | Effective (throttled) clock in the same format |

## Verification
Two events can fall in the same cycle: a window closing, and the divider still finishing the result of an earlier window. The sweep provokes this with short windows (twenty cycles against a divider latency above eighty) and with configuration changes that shorten a window in progress. A bench-side model applies the acceptance rule from R8 cycle by cycle. Every cycle is judged against that model: a pulse must appear exactly when an accepted window's latency expires, a dropped window must never produce a pulse, and the values must match the counts the model kept for the window.

// File: rtl/eff_clock_monitor.sv
module eff_clock_monitor #(
  parameter int CNT_W     = 32,
  parameter int WIN_W     = 16,
  parameter int THREADS   = 2,
  parameter int RATE_FRAC = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ref_tick,
  input  logic [THREADS-1:0]         thread_busy,
  input  logic                       forced_idle,
  input  logic                       full_load_sample,
  input  logic [WIN_W-1:0]           win_len,
  output logic                       result_valid,
  output logic [15:0]                load_frac,
  output logic [CNT_W+RATE_FRAC-1:0] rate,
  output logic [CNT_W+RATE_FRAC-1:0] eff_rate
);

  localparam int DW = CNT_W + 16;
  localparam int RW = CNT_W + RATE_FRAC;
  localparam int SW = $clog2(DW);

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_EFF, PH_RATE} phase_t;

  logic [WIN_W-1:0] tick_cnt;
  logic [CNT_W-1:0] tot_c, bsy_c, stot_c, sbsy_c;
  logic [CNT_W-1:0] tot_n, bsy_n, stot_n, sbsy_n;

  wire en        = win_len != '0;
  wire core_busy = (|thread_busy) && !forced_idle;
  wire close     = en && ref_tick &&
                   (({1'b0, tick_cnt} + (WIN_W+1)'(1)) >= {1'b0, win_len});

  assign tot_n  = tot_c + CNT_W'(1);
  assign bsy_n  = bsy_c + CNT_W'(core_busy);
  assign stot_n = stot_c + CNT_W'(full_load_sample);
  assign sbsy_n = sbsy_c + CNT_W'(full_load_sample && core_busy);

  always_ff @(posedge clk) begin
    if (rst || !en || close) begin
      tick_cnt <= '0;
      tot_c    <= '0;
      bsy_c    <= '0;
      stot_c   <= '0;
      sbsy_c   <= '0;
    end else begin
      tick_cnt <= tick_cnt + WIN_W'(ref_tick);
      tot_c    <= tot_n;
      bsy_c    <= bsy_n;
      stot_c   <= stot_n;
      sbsy_c   <= sbsy_n;
    end
  end

  phase_t           phase;
  logic [SW-1:0]    step;
  logic [DW-1:0]    dvd, quo;
  logic [CNT_W-1:0] rem, dsr;
  logic [CNT_W-1:0] snap_tot, snap_sbsy, snap_stot, snap_win;
  logic [15:0]      load_r, eff_r;

  wire [CNT_W:0]  trial = {rem, dvd[DW-1]};
  wire            fits  = trial >= {1'b0, dsr};
  wire [CNT_W:0]  diff  = trial - {1'b0, dsr};
  wire [DW-1:0]   quo_n = {quo[DW-2:0], fits};
  wire            last  = step == SW'(DW-1);
  wire [15:0]     sat   = (|quo_n[DW-1:16]) ? 16'hFFFF : quo_n[15:0];
  wire [RW+15:0]  prod  = {{RW{1'b0}}, eff_r} * {16'b0, quo_n[RW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      step         <= '0;
      dvd          <= '0;
      quo          <= '0;
      rem          <= '0;
      dsr          <= '0;
      snap_tot     <= '0;
      snap_sbsy    <= '0;
      snap_stot    <= '0;
      snap_win     <= '0;
      load_r       <= '0;
      eff_r        <= '0;
      result_valid <= 1'b0;
      load_frac    <= '0;
      rate         <= '0;
      eff_rate     <= '0;
    end else begin
      result_valid <= 1'b0;
      if (phase == PH_IDLE) begin
        if (close) begin
          dvd       <= {bsy_n, 16'b0};
          dsr       <= tot_n;
          snap_tot  <= tot_n;
          snap_sbsy <= sbsy_n;
          snap_stot <= stot_n;
          snap_win  <= CNT_W'(win_len);
          rem       <= '0;
          quo       <= '0;
          step      <= '0;
          phase     <= PH_LOAD;
        end
      end else if (!last) begin
        dvd  <= {dvd[DW-2:0], 1'b0};
        rem  <= fits ? diff[CNT_W-1:0] : trial[CNT_W-1:0];
        quo  <= quo_n;
        step <= step + SW'(1);
      end else begin
        rem  <= '0;
        quo  <= '0;
        step <= '0;
        case (phase)
          PH_LOAD: begin
            load_r <= sat;
            dvd    <= {snap_sbsy, 16'b0};
            dsr    <= snap_stot;
            phase  <= PH_EFF;
          end
          PH_EFF: begin
            eff_r  <= sat;
            dvd    <= {16'b0, snap_tot} << RATE_FRAC;
            dsr    <= snap_win;
            phase  <= PH_RATE;
          end
          default: begin
            rate         <= quo_n[RW-1:0];
            load_frac    <= load_r;
            eff_rate     <= prod[RW+15:16];
            result_valid <= 1'b1;
            phase        <= PH_IDLE;
          end
        endcase
      end
    end
  end

  a_r4_busy_within_total: assert property (@(posedge clk) disable iff (rst)
    bsy_c <= tot_c);

  a_r6_sample_within_total: assert property (@(posedge clk) disable iff (rst)
    (sbsy_c <= stot_c) && (stot_c <= tot_c) && (sbsy_c <= bsy_c));

  a_r6_eff_not_above_rate: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (eff_rate <= rate));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> ($stable(load_frac) && $stable(rate) && $stable(eff_rate)));

  a_r9_disabled_clears: assert property (@(posedge clk) disable iff (rst)
    (win_len == '0) |=> (tot_c == '0 && tick_cnt == '0));

endmodule

// File: tb/tb_eff_clock_monitor.sv
`timescale 1ns/1ps
module tb_eff_clock_monitor;
  localparam int CW  = 12;
  localparam int WW  = 8;
  localparam int TH  = 2;
  localparam int RF  = 8;
  localparam int RW  = CW + RF;
  localparam int LAT = 3 * (CW + 16);

  logic clk = 1'b0, rst = 1'b1, ref_tick = 1'b0, forced_idle = 1'b0, samp = 1'b0;
  logic [TH-1:0] tbusy = '0;
  logic [WW-1:0] win = '0;
  logic          valid;
  logic [15:0]   load_frac;
  logic [RW-1:0] rate, eff_rate;

  eff_clock_monitor #(.CNT_W(CW), .WIN_W(WW), .THREADS(TH), .RATE_FRAC(RF)) dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .thread_busy(tbusy),
    .forced_idle(forced_idle), .full_load_sample(samp), .win_len(win),
    .result_valid(valid), .load_frac(load_frac), .rate(rate), .eff_rate(eff_rate));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, drops = 0, head = 0, tail = 0;
  bit done = 1'b0;
  longint n = 0, last_acc = -100000, low_at = -1;
  longint m_t = 0, m_b = 0, m_st = 0, m_sb = 0, m_tick = 0;
  longint q_cyc[512], q_load[512], q_rate[512], q_eff[512];
  int     q_mode[512];
  longint last_load = 0, last_rate = 0, last_eff = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe();
    if (head < tail && n == q_cyc[head]) begin
      check(valid, "R7 pulse at expected cycle", longint'(valid), 1);
      check(rate == q_rate[head], "R2 R3 rate", rate, q_rate[head]);
      if (q_mode[head] == 1 || q_mode[head] == 3)
        check(load_frac == q_load[head], "R4 R5 R10 load with threads and idle", load_frac, q_load[head]);
      else
        check(load_frac == q_load[head], "R4 load", load_frac, q_load[head]);
      check(eff_rate == q_eff[head], "R6 effective clock", eff_rate, q_eff[head]);
      last_load = q_load[head]; last_rate = q_rate[head]; last_eff = q_eff[head];
      head++;
      low_at = n + 1;
    end else if (n == low_at) begin
      check(!valid, "R7 pulse one cycle wide", longint'(valid), 0);
    end else if (valid) begin
      check(1'b0, "R8 result from dropped or absent window", 1, 0);
    end
  endtask

  task automatic drive(input int p, input int w, input int mode);
    bit rt, fi, sp, cb;
    logic [TH-1:0] tb;
    longint q, ld, rt_e;
    rt = (n % p) == 0;
    case (mode)
      0: begin tb = '1; fi = 1'b0; sp = 1'b1; end
      1: begin
        tb = {((n % 3) == 0), ((n % 5) < 3)};
        fi = (n % 8) < 2;
        sp = (n % 50) < 20;
      end
      2: begin tb = '0; fi = (n % 4) == 0; sp = (n % 10) < 5; end
      default: begin
        tb = {((n % 7) > 1), ((n % 7) < 5)};
        fi = (n % 16) < 6;
        sp = 1'b0;
      end
    endcase
    ref_tick = rt; tbusy = tb; forced_idle = fi; samp = sp; win = WW'(w);
    cb = (|tb) && !fi;
    if (w == 0) begin
      m_t = 0; m_b = 0; m_st = 0; m_sb = 0; m_tick = 0;
    end else begin
      m_t++; m_b += cb; m_st += sp; m_sb += (sp && cb);
      if (rt && (m_tick + 1 >= w)) begin
        if (n - last_acc > LAT) begin
          ld = (m_b * 65536) / m_t;
          if (ld > 65535) ld = 65535;
          q = (m_st == 0) ? 65535 : (m_sb * 65536) / m_st;
          if (q > 65535) q = 65535;
          rt_e = (m_t * 256) / w;
          q_cyc[tail] = n + LAT + 1; q_load[tail] = ld; q_rate[tail] = rt_e;
          q_eff[tail] = (q * rt_e) >> 16; q_mode[tail] = mode;
          tail++;
          last_acc = n;
        end else begin
          drops++;
        end
        m_t = 0; m_b = 0; m_st = 0; m_sb = 0; m_tick = 0;
      end else begin
        m_tick += rt;
      end
    end
    n++;
  endtask

  task automatic run(input int p, input int w, input int mode, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      observe();
      drive(p, w, mode);
    end
  endtask

  int cp[12] = '{1, 2, 3, 5, 1, 4, 3, 7, 2, 1, 6, 3};
  int cw[12] = '{120, 60, 50, 30, 20, 0, 45, 20, 90, 255, 35, 70};
  int cn[12] = '{400, 400, 500, 500, 300, 150, 500, 450, 600, 800, 700, 700};

  initial begin
    repeat (4) @(negedge clk);
    check(!valid, "R1 valid low in reset", longint'(valid), 0);
    check(load_frac == 0 && rate == 0 && eff_rate == 0, "R1 outputs zero in reset",
          longint'(load_frac) + rate + eff_rate, 0);
    rst = 1'b0;
    drive(1, 120, 0);
    @(negedge clk);
    observe();
    check(!valid && rate == 0, "R1 outputs zero after release", rate, 0);
    drive(1, 120, 0);
    for (int c = 0; c < 12; c++) begin
      run(cp[c], cw[c], c % 4, cn[c]);
      if (cw[c] == 0)
        check(m_t == 0 && load_frac == last_load && rate == last_rate,
              "R9 disabled holds outputs", rate, last_rate);
    end
    run(1, 0, 0, LAT + 10);
    check(head == tail, "R8 every accepted window reported", head, tail);
    check(drops > 0, "R8 short windows were dropped", drops, 1);
    check(rate == last_rate && eff_rate == last_eff && load_frac == last_load,
          "R9 outputs held while disabled", rate, last_rate);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule